// File: doc/BRIEF.md
# Oversampled Serial Receive Engine with Error Gating

This block turns an asynchronous, idle-high serial line into characters held in a small receive queue. The line is sampled on an oversampling strobe that runs at sixteen times the bit rate. A falling edge arms the receiver, and the start bit is confirmed halfway through its period. Data bits are then taken at the centre of each bit period, in either bit order, followed by an optional parity bit and one or two stop bits. When the frame closes, a chain of checks decides whether the character enters the queue or raises one of four sticky error flags: overrun, parity, framing or break.

Software reads the queue through a show-ahead head register and a pop strobe. It clears each flag with its own strobe. A single enable gates three interrupt requests: data available, receive error and break. An overrun always stops further reception until the overrun flag is cleared. A parity or framing error stops reception only when the halt-on-error control is set.

Top module: `serial_rx_engine`

## Requirements
- R1: A frame starts only on a high-to-low transition of the line seen on an oversampling strobe. The line is checked again at the middle of the start bit, and a low pulse that has ended by then is ignored: it stores nothing and sets no flag.
- R2: With `cfg_msb_first` = 0 the first data bit received lands in bit 0 of the character. With `cfg_msb_first` = 1 it lands in bit 7.
- R3: With `cfg_par_en` = 1, the data bits plus the parity bit must hold an even number of ones when `cfg_par_odd` = 0, and an odd number when it is 1. A mismatch sets `flag_par` and the character is discarded.
- R4: A 0 in the first stop bit sets `flag_frm` and the character is discarded. With `cfg_two_stop` = 1 the second stop bit is waited out but not checked.
- R5: A character that completes while the queue holds DEPTH (16) entries sets `flag_ovr` and is discarded. While `flag_ovr` is set, no later frame is received, even after space frees up.
- R6: With `cfg_halt_on_err` = 1, no frame is received while `flag_par` or `flag_frm` is set. With it at 0, reception goes on and good characters are stored.
- R7: A frame whose data, parity and first stop positions are all 0 sets `flag_brk` (not `flag_frm`) and stores nothing. While `flag_brk` is set, otherwise valid characters are discarded.
- R8: `flag_rdy` is high when the queue level is nonzero and at least `cfg_trig`, and none of `flag_ovr`, `flag_par` or `flag_frm` is set.
- R9: With `cfg_irq_en` = 1: `irq_data` follows `flag_rdy`, `irq_err` is the OR of the overrun, parity and framing flags, and `irq_brk` follows `flag_brk`. With `cfg_irq_en` = 0 all three are low.
- R10: `rd_data` shows the oldest stored character. A `rd_pop` pulse removes it, and a pop on an empty queue has no effect.
- R11: Each flag stays set until its clear strobe is pulsed. A new setting event in the same cycle as the clear wins.
- R12: After reset the queue is empty, and all flags and interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_msb_first | input | 1 | 1: first data bit is the MSB |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Frame carries two stop bits |
| cfg_halt_on_err | input | 1 | Halt reception on parity or framing error |
| cfg_irq_en | input | 1 | Enable for all three interrupt requests |
| cfg_trig | input | 5 | Queue level at which `flag_rdy` asserts |
| rd_pop | input | 1 | Remove the head character |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_par | input | 1 | Clear parity flag |
| clr_frm | input | 1 | Clear framing flag |
| clr_brk | input | 1 | Clear break flag |
| rd_data | output | 8 | Head character of the queue |
| rx_level | output | 5 | Number of stored characters |
| flag_ovr | output | 1 | Overrun error |
| flag_par | output | 1 | Parity error |
| flag_frm | output | 1 | Framing error |
| flag_brk | output | 1 | Break received |
| flag_rdy | output | 1 | Data ready at trigger level |
| irq_data | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
On every cycle, the assertions check several properties that hold at all times. The interrupt requests must stay silent without the enable. An error interrupt must always have a flag behind it. The queue level never exceeds its depth. A parity, framing or break flag never rises in the same cycle as a queue write, and the level never grows while an overrun persists. The bench scenarios show the rest, which depends on serial timing and data: glitch rejection, the two bit orders, parity polarity, the unchecked second stop bit, the halt/continue choice, and reception resuming once the flags are cleared.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial receive engine.
// Assumes an 8-bit character unless the parameter is overridden at each user.
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              stop_err;
        logic              all_zero;
    } frame_res_t;

endpackage

// File: rtl/serial_rx_sync.sv
// Line synchronizer: two flops bring the serial line into the clock domain,
// and a third flop, updated only on the oversampling strobe, finds falling edges.
// Assumes the line idles high; every flop resets to 1 so no false edge is seen.
module serial_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    logic s1, s2, s_prev;

    // Two-flop synchronizer plus tick-rate history bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s1 <= line_i;
            s2 <= s1;
            if (tick) s_prev <= s2;
        end
    end

    assign line_o = s2;
    assign fall_o = s_prev & ~s2;
endmodule

// File: rtl/serial_rx_frame.sv
// Frame sequencer: confirms the start bit at mid-bit, samples data, parity and
// stop bits at their centres, and emits a one-cycle done pulse with the results.
// Assumes OSR ticks per bit (OSR even) and a synchronized line input.
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       fall,
    input  logic       block,
    input  logic       msb_first,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    output logic       done,
    output frame_res_t res
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              any_one;

    // Frame state machine, advanced on oversampling strobes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            any_one <= 1'b0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (fall && !block) state <= RX_START;
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            cnt     <= '0;
                            bitn    <= '0;
                            any_one <= 1'b0;
                            par_bit <= 1'b0;
                            state   <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (msb_first) shreg <= {shreg[DATA_W-2:0], line};
                            else           shreg <= {line, shreg[DATA_W-1:1]};
                            any_one <= any_one | line;
                            if (bitn == TOP) state <= par_en ? RX_PAR : RX_STOP1;
                            else             bitn  <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bit <= line;
                            any_one <= any_one | line;
                            state   <= RX_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP1: begin
                        if (cnt == LAST) begin
                            cnt          <= '0;
                            done         <= 1'b1;
                            res.data     <= shreg;
                            res.stop_err <= ~line;
                            res.par_err  <= par_en & ((^shreg ^ par_bit) != par_odd);
                            res.all_zero <= ~any_one & ~line;
                            state        <= two_stop ? RX_STOP2 : RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP2: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_rx_fifo.sv
// Receive queue: DEPTH entries with a show-ahead head and a level count.
// Assumes the writer never pushes when full; a pop on an empty queue is dropped.
module serial_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [DW-1:0]              wdata,
    input  logic                       rd,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]    LAST_A = AW'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_rd;

    assign do_rd = rd && (level != '0);
    assign full  = (level == FULL_L);
    assign rdata = mem[rp];

    // Storage array, written without reset
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= wdata;
    end

    // Pointers and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr)    wp <= (wp == LAST_A) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST_A) ? '0 : rp + 1'b1;
            level <= level + LVL_W'(wr) - LVL_W'(do_rd);
        end
    end
endmodule

// File: rtl/serial_rx_engine.sv
// Top of the serial receive engine: runs the frame checks, keeps the sticky
// error flags, gates reception on overrun or halting errors, and forms the
// interrupt requests. Assumes os_tick pulses OSR times per bit period.
module serial_rx_engine
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OSR    = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd_i,
    input  logic              cfg_msb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_halt_on_err,
    input  logic              cfg_irq_en,
    input  logic [LVL_W-1:0]  cfg_trig,
    input  logic              rd_pop,
    input  logic              clr_ovr,
    input  logic              clr_par,
    input  logic              clr_frm,
    input  logic              clr_brk,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  rx_level,
    output logic              flag_ovr,
    output logic              flag_par,
    output logic              flag_frm,
    output logic              flag_brk,
    output logic              flag_rdy,
    output logic              irq_data,
    output logic              irq_err,
    output logic              irq_brk
);
    logic       line_s, fall_s, block, done, full, err_any;
    logic       set_ovr, set_par, set_frm, set_brk, wr_ok;
    frame_res_t res;

    serial_rx_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .line_i (rxd_i),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    serial_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .line      (line_s),
        .fall      (fall_s),
        .block     (block),
        .msb_first (cfg_msb_first),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .two_stop  (cfg_two_stop),
        .done      (done),
        .res       (res)
    );

    serial_rx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ok),
        .wdata (res.data),
        .rd    (rd_pop),
        .rdata (rd_data),
        .level (rx_level),
        .full  (full)
    );

    // Check chain at frame end: break, then stop, parity, room, break flag
    always_comb begin
        set_brk = done &  res.all_zero;
        set_frm = done & ~res.all_zero &  res.stop_err;
        set_par = done & ~res.all_zero & ~res.stop_err & res.par_err;
        set_ovr = done & ~res.all_zero & ~res.stop_err & ~res.par_err & full;
        wr_ok   = done & ~res.all_zero & ~res.stop_err & ~res.par_err & ~full & ~flag_brk;
    end

    // Sticky flags: a set event outranks its clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ovr <= 1'b0;
            flag_par <= 1'b0;
            flag_frm <= 1'b0;
            flag_brk <= 1'b0;
        end else begin
            flag_ovr <= set_ovr | (flag_ovr & ~clr_ovr);
            flag_par <= set_par | (flag_par & ~clr_par);
            flag_frm <= set_frm | (flag_frm & ~clr_frm);
            flag_brk <= set_brk | (flag_brk & ~clr_brk);
        end
    end

    // Reception gating and status/interrupt outputs
    always_comb begin
        err_any  = flag_ovr | flag_par | flag_frm;
        block    = flag_ovr | (cfg_halt_on_err & (flag_par | flag_frm));
        flag_rdy = (rx_level != '0) && (rx_level >= cfg_trig) && !err_any;
        irq_data = cfg_irq_en & flag_rdy;
        irq_err  = cfg_irq_en & err_any;
        irq_brk  = cfg_irq_en & flag_brk;
    end
endmodule

// File: rtl/serial_rx_engine_chk.sv
// Property checker for the serial receive engine, bound to every instance.
// Assumes DEPTH matches the bound instance's queue depth.
module serial_rx_engine_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_irq_en,
    input logic [LVL_W-1:0] rx_level,
    input logic             flag_ovr,
    input logic             flag_par,
    input logic             flag_frm,
    input logic             flag_brk,
    input logic             irq_data,
    input logic             irq_err,
    input logic             irq_brk
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(DEPTH)); // R10
    AST_OVR_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovr && $past(flag_ovr)) |-> rx_level <= $past(rx_level)); // R5
    AST_PAR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_par) |-> rx_level <= $past(rx_level)); // R3
    AST_FRM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_frm) |-> rx_level <= $past(rx_level)); // R4
    AST_BRK_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_brk) |-> rx_level <= $past(rx_level)); // R7
    AST_IRQ_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !(irq_data || irq_err || irq_brk)); // R9
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (flag_ovr || flag_par || flag_frm)); // R9
    AST_RDY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovr || flag_par || flag_frm) |-> !irq_data); // R8
endmodule

bind serial_rx_engine serial_rx_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_irq_en (cfg_irq_en),
    .rx_level   (rx_level),
    .flag_ovr   (flag_ovr),
    .flag_par   (flag_par),
    .flag_frm   (flag_frm),
    .flag_brk   (flag_brk),
    .irq_data   (irq_data),
    .irq_err    (irq_err),
    .irq_brk    (irq_brk)
);

// File: tb/serial_rx_engine_tb_top.sv
`timescale 1ns/1ps
module serial_rx_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd_i = 1'b1;
    logic       cfg_msb_first = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0, cfg_halt_on_err = 1'b0, cfg_irq_en = 1'b0;
    logic [4:0] cfg_trig = 5'd1;
    logic       rd_pop = 1'b0;
    logic       clr_ovr = 1'b0, clr_par = 1'b0, clr_frm = 1'b0, clr_brk = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] rx_level;
    logic       flag_ovr, flag_par, flag_frm, flag_brk, flag_rdy;
    logic       irq_data, irq_err, irq_brk;
    int         checks = 0;
    int         errors = 0;
    bit         timed_out = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_i(rxd_i),
        .cfg_msb_first(cfg_msb_first), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .cfg_halt_on_err(cfg_halt_on_err), .cfg_irq_en(cfg_irq_en),
        .cfg_trig(cfg_trig), .rd_pop(rd_pop), .clr_ovr(clr_ovr),
        .clr_par(clr_par), .clr_frm(clr_frm), .clr_brk(clr_brk),
        .rd_data(rd_data), .rx_level(rx_level), .flag_ovr(flag_ovr),
        .flag_par(flag_par), .flag_frm(flag_frm), .flag_brk(flag_brk),
        .flag_rdy(flag_rdy), .irq_data(irq_data), .irq_err(irq_err),
        .irq_brk(irq_brk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic b);
        rxd_i = b;
        repeat (16) @(negedge clk);
    endtask

    // Serialize a frame; wire_msb picks the order put on the line
    task automatic send(input logic [7:0] d, input bit wire_msb, input bit par_flip,
                        input logic stop1, input logic stop2);
        hold(1'b0);
        for (int i = 0; i < 8; i++) hold(wire_msb ? d[7-i] : d[i]);
        if (cfg_par_en) hold((^d) ^ cfg_par_odd ^ par_flip);
        hold(stop1);
        if (cfg_two_stop) hold(stop2);
        rxd_i = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic good(input logic [7:0] d);
        send(d, cfg_msb_first, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic pop();
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clears();
        clr_ovr = 1'b1; clr_par = 1'b1; clr_frm = 1'b1; clr_brk = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0; clr_par = 1'b0; clr_frm = 1'b0; clr_brk = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        while (rx_level != 0) pop();
    endtask

    task automatic t_reset();
        chk("R12 level", rx_level, 0);
        chk("R12 flags", {flag_ovr, flag_par, flag_frm, flag_brk, flag_rdy}, 0);
        chk("R12 irqs", {irq_data, irq_err, irq_brk}, 0);
    endtask

    task automatic t_glitch();
        rxd_i = 1'b0; repeat (4) @(negedge clk); rxd_i = 1'b1;
        repeat (300) @(negedge clk);
        chk("R1 glitch level", rx_level, 0);
        chk("R1 glitch flags", {flag_ovr, flag_par, flag_frm, flag_brk}, 0);
        good(8'h5A);
        chk("R1 frame after glitch", rd_data, 8'h5A);
        drain();
    endtask

    task automatic t_order();
        cfg_msb_first = 1'b0; good(8'h35);
        chk("R2 lsb-first data", rd_data, 8'h35); drain();
        cfg_msb_first = 1'b1; good(8'h35);
        chk("R2 msb-first data", rd_data, 8'h35); drain();
        send(8'hA6, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R2 msb-first reverses lsb wire", rd_data, 8'h65); drain();
        cfg_msb_first = 1'b0;
    endtask

    task automatic t_parity();
        cfg_par_en = 1'b1; cfg_irq_en = 1'b1;
        cfg_par_odd = 1'b0; good(8'h07);
        chk("R3 even parity stored", {rx_level, rd_data}, {5'd1, 8'h07}); drain();
        cfg_par_odd = 1'b1; good(8'h07);
        chk("R3 odd parity stored", {rx_level, rd_data}, {5'd1, 8'h07}); drain();
        send(8'h07, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R3 parity error flag", flag_par, 1);
        chk("R3 parity error discards", rx_level, 0);
        chk("R9 irq_err on parity", irq_err, 1);
        cfg_irq_en = 1'b0; @(negedge clk);
        chk("R9 irqs muted", {irq_data, irq_err, irq_brk}, 0);
        clr_par = 1'b1; @(negedge clk); clr_par = 1'b0; @(negedge clk);
        chk("R11 parity flag cleared", flag_par, 0);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_stop();
        send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 framing flag", {flag_frm, flag_brk}, 2'b10);
        chk("R4 framing discards", rx_level, 0);
        pulse_clears();
        cfg_two_stop = 1'b1;
        send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4 second stop unchecked", {flag_frm, rx_level, rd_data}, {1'b0, 5'd1, 8'h3C});
        drain(); cfg_two_stop = 1'b0;
    endtask

    task automatic t_halt();
        cfg_par_en = 1'b1; cfg_halt_on_err = 1'b1;
        send(8'h11, 1'b0, 1'b1, 1'b1, 1'b1);
        good(8'h22);
        chk("R6 halted while parity flag set", rx_level, 0);
        pulse_clears(); good(8'h23);
        chk("R6 resumes after clear", {rx_level, rd_data}, {5'd1, 8'h23}); drain();
        cfg_halt_on_err = 1'b0;
        send(8'h11, 1'b0, 1'b1, 1'b1, 1'b1);
        good(8'h24);
        chk("R6 continues with error set", {flag_par, rx_level, rd_data}, {1'b1, 5'd1, 8'h24});
        chk("R8 rdy blocked by error flag", flag_rdy, 0);
        drain(); pulse_clears(); cfg_par_en = 1'b0;
    endtask

    task automatic t_break();
        cfg_irq_en = 1'b1;
        for (int i = 0; i < 10; i++) hold(1'b0);
        rxd_i = 1'b1; repeat (40) @(negedge clk);
        chk("R7 break flag, no framing", {flag_brk, flag_frm, rx_level}, {1'b1, 1'b0, 5'd0});
        chk("R9 irq_brk", irq_brk, 1);
        good(8'h77);
        chk("R7 discard while break set", rx_level, 0);
        pulse_clears(); good(8'h78);
        chk("R7 stored after clear", {rx_level, rd_data}, {5'd1, 8'h78});
        drain();
    endtask

    task automatic t_overrun();
        cfg_trig = 5'd16;
        for (int i = 0; i < 16; i++) begin
            good(8'h80 + 8'(i));
            if (i == 14) chk("R8 rdy below trigger", flag_rdy, 0);
        end
        chk("R8 rdy at trigger", {rx_level, flag_rdy}, {5'd16, 1'b1});
        chk("R9 irq_data", irq_data, 1);
        good(8'hEE);
        chk("R5 overrun flag", {flag_ovr, rx_level}, {1'b1, 5'd16});
        chk("R8 rdy dropped by overrun", flag_rdy, 0);
        pop(); good(8'hEF);
        chk("R5 blocked until cleared", rx_level, 15);
        clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
        good(8'hF0);
        chk("R5 resumes after clear", {flag_ovr, rx_level, rd_data}, {1'b0, 5'd16, 8'h81});
        drain(); cfg_trig = 5'd1; cfg_irq_en = 1'b0;
    endtask

    task automatic t_empty_pop();
        good(8'h42); pop(); pop(); pop();
        chk("R10 pop on empty", rx_level, 0);
        good(8'h43);
        chk("R10 head after empty pops", {rx_level, rd_data}, {5'd1, 8'h43});
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        fork
            begin
                t_reset(); t_glitch(); t_order(); t_parity(); t_stop();
                t_halt(); t_break(); t_overrun(); t_empty_pop();
            end
            begin
                wait (timed_out);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule